// File: doc/BRIEF.md
# Prioritized Latched Interrupt Controller

This block sits beside a small CPU core. It collects one-cycle interrupt events from a set of sources and holds each one in its own pending latch. A source makes a request only while its latch is set and its enable bit is set. The default build has eight sources. Sources 0 to 2 are general sources, each enabled through a small general enable register. Sources 3 to 7 are the five USB endpoint sources, enabled through an 8-bit endpoint enable register.

When the core reports an instruction boundary and the global enable is set, the block takes the lowest-numbered request, which is the highest priority. In one step it clears the global enable and clears that source's pending latch. On the next cycle it issues a one-cycle call strobe together with the source's vector address, which comes from a parameter table.

The core controls the global enable with three commands: enable, disable and return-from-interrupt. It can read a status word holding the global enable and a sense flag. The sense flag shows a masked but pending request while the global enable is clear.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the global enable is 0, both enable registers read 0, every pending latch is 0 and the call strobe is low.
- R2: In the endpoint enable register, bit 0 enables source 3 (endpoint A0), bit 1 source 4 (A1), bit 2 source 5 (A2), bit 3 source 6 (B0) and bit 4 source 7 (B1). Bits 7..5 always read 0, and writes to them have no effect.
- R3: A source event sets that source's pending latch at the next clock edge. The latch stays set until the source is serviced or reset is applied.
- R4: A pending source whose enable bit is clear never causes a call.
- R5: An interrupt is taken at a clock edge where instrDone is high, the global enable is 1 and at least one request exists. On the following cycle callStrobe is high for exactly one cycle.
- R6: The taken source is the lowest-indexed request. Along with the strobe, callVector gives that source's table entry, which is 4 + 2*index by default.
- R7: Taking an interrupt clears the global enable and the pending latch of the served source only.
- R8: Enable sets the global enable and disable clears it. When both arrive in the same cycle, disable wins. Neither command changes the enable registers or the pending latches.
- R9: Return-from-interrupt sets the global enable. A take in the same cycle overrides it.
- R10: Status bit 2 is the global enable. Status bit 7 is 1 whenever any enabled source is pending, even with the global enable clear. All other status bits are 0.
- R11: If a new event for a source arrives in the cycle that source is serviced, its pending latch stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | One-cycle event pulses, one bit per source |
| instrDone | input | 1 | The current instruction completes this cycle |
| cmdEi | input | 1 | Enable-interrupts command |
| cmdDi | input | 1 | Disable-interrupts command |
| cmdReti | input | 1 | Return-from-interrupt command |
| epEnWr | input | 1 | Write strobe for the endpoint enable register |
| epEnWdata | input | 8 | Endpoint enable write data |
| epEnRdata | output | 8 | Endpoint enable read data |
| genEnWr | input | 1 | Write strobe for the general enable register |
| genEnWdata | input | NUM_GEN | General enable write data |
| genEnRdata | output | NUM_GEN | General enable read data |
| callStrobe | output | 1 | One-cycle call-to-vector command |
| callVector | output | VEC_W | Vector address, valid while callStrobe is high |
| status | output | 8 | Bit 7 is the sense flag, bit 2 is the global enable |
| pending | output | NUM_SRC | Pending latches |

## Verification
Pending latches, enable registers and the global enable change at the edge that samples their cause, so they are due one cycle after the stimulus is driven. The call strobe and vector are registered after the take decision, so they appear in the cycle after the edge where instrDone was seen. The status word follows the registers with no further delay. The bench drives inputs on the falling edge and advances a bench-side model at the rising edge. It compares every output at the next falling edge, so each expectation is checked in exactly the cycle its result is due.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int MAX_SRC   = 16;
  localparam int IDX_W     = 4;
  localparam int GIE_BIT   = 2;
  localparam int SENSE_BIT = 7;

  typedef struct packed {
    logic             take;
    logic [IDX_W-1:0] selIdx;
  } ctlStb_t;
endpackage

// File: rtl/irq_control.sv
module irq_control
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqVec,
  input  logic               instrDone,
  input  logic               cmdEi,
  input  logic               cmdDi,
  input  logic               cmdReti,
  output ctlStb_t            ctl,
  output logic               gie,
  output logic               sense
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic             gieQ;
  logic [IDX_W-1:0] selIdx;
  logic             anyReq;

  // scan from the top down so the lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign anyReq     = |reqVec;
  assign ctl.take   = instrDone & gieQ & anyReq;
  assign ctl.selIdx = selIdx;
  assign gie        = gieQ;
  assign sense      = anyReq;

  always_ff @(posedge clk) begin
    if (!rstN)                  gieQ <= 1'b0;
    else if (ctl.take)          gieQ <= 1'b0;
    else if (cmdDi)             gieQ <= 1'b0;
    else if (cmdEi || cmdReti)  gieQ <= 1'b1;
  end

  // R7
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |=> !gieQ);
  // R6
  take_has_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> reqVec[ctl.selIdx[SEL_W-1:0]]);
  // R8
  di_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDi |=> !gieQ);
  // R9
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReti && !cmdDi && !ctl.take) |=> gieQ);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_GEN = 3,
  parameter int EP_W    = 8,
  parameter int VEC_W   = 12,
  parameter logic [NUM_SRC-1:0][VEC_W-1:0] VEC_TABLE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  ctlStb_t            ctl,
  input  logic               epEnWr,
  input  logic [EP_W-1:0]    epEnWdata,
  output logic [EP_W-1:0]    epEnRdata,
  input  logic               genEnWr,
  input  logic [NUM_GEN-1:0] genEnWdata,
  output logic [NUM_GEN-1:0] genEnRdata,
  output logic [NUM_SRC-1:0] reqVec,
  output logic [NUM_SRC-1:0] pendQ,
  output logic               callStbQ,
  output logic [VEC_W-1:0]   callVecQ
);
  localparam int NUM_EP = NUM_SRC - NUM_GEN;
  localparam int SEL_W  = $clog2(NUM_SRC);

  logic [NUM_EP-1:0]  epEnQ;
  logic [NUM_GEN-1:0] genEnQ;
  logic [NUM_SRC-1:0] clrOh;
  logic [SEL_W-1:0]   sel;

  assign sel    = ctl.selIdx[SEL_W-1:0];
  assign clrOh  = ctl.take ? (NUM_SRC'(1) << sel) : '0;
  assign reqVec = pendQ & {epEnQ, genEnQ};

  generate
    if (EP_W > NUM_EP) begin : g_pad
      assign epEnRdata = {{(EP_W-NUM_EP){1'b0}}, epEnQ};
    end else begin : g_nopad
      assign epEnRdata = epEnQ;
    end
  endgenerate
  assign genEnRdata = genEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      epEnQ    <= '0;
      genEnQ   <= '0;
      callStbQ <= 1'b0;
      callVecQ <= '0;
    end else begin
      // an event landing on a clear keeps the latch set
      pendQ    <= (pendQ & ~clrOh) | srcEvent;
      callStbQ <= ctl.take;
      if (ctl.take) callVecQ <= VEC_TABLE[sel];
      if (epEnWr)   epEnQ    <= epEnWdata[NUM_EP-1:0];
      if (genEnWr)  genEnQ   <= genEnWdata;
    end
  end

  // R3
  pend_needs_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ & ~$past(pendQ) & ~$past(srcEvent)) == '0);
  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    callStbQ |=> !callStbQ);
  // R7
  clear_served_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && !srcEvent[sel]) |=> !pendQ[$past(sel)]);
  // R11
  keep_on_collision_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && srcEvent[sel]) |=> pendQ[$past(sel)]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_GEN = 3,
  parameter int VEC_W   = 12,
  parameter logic [NUM_SRC-1:0][VEC_W-1:0] VEC_TABLE =
    {12'h012, 12'h010, 12'h00E, 12'h00C, 12'h00A, 12'h008, 12'h006, 12'h004}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               instrDone,
  input  logic               cmdEi,
  input  logic               cmdDi,
  input  logic               cmdReti,
  input  logic               epEnWr,
  input  logic [7:0]         epEnWdata,
  output logic [7:0]         epEnRdata,
  input  logic               genEnWr,
  input  logic [NUM_GEN-1:0] genEnWdata,
  output logic [NUM_GEN-1:0] genEnRdata,
  output logic               callStrobe,
  output logic [VEC_W-1:0]   callVector,
  output logic [7:0]         status,
  output logic [NUM_SRC-1:0] pending
);
  ctlStb_t            ctl;
  logic [NUM_SRC-1:0] reqVec;
  logic               gie;
  logic               sense;

  irq_control #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .instrDone(instrDone),
    .cmdEi(cmdEi), .cmdDi(cmdDi), .cmdReti(cmdReti),
    .ctl(ctl), .gie(gie), .sense(sense)
  );

  irq_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_GEN(NUM_GEN), .EP_W(8),
    .VEC_W(VEC_W), .VEC_TABLE(VEC_TABLE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .ctl(ctl),
    .epEnWr(epEnWr), .epEnWdata(epEnWdata), .epEnRdata(epEnRdata),
    .genEnWr(genEnWr), .genEnWdata(genEnWdata), .genEnRdata(genEnRdata),
    .reqVec(reqVec), .pendQ(pending),
    .callStbQ(callStrobe), .callVecQ(callVector)
  );

  always_comb begin
    status            = '0;
    status[GIE_BIT]   = gie;
    status[SENSE_BIT] = sense;
  end

  // R10
  sense_no_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (callStrobe && (pending == '0)) |-> !status[SENSE_BIT]);
  // R5
  strobe_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(callStrobe) |-> !status[GIE_BIT]);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcEvent = '0;
  logic       instrDone = 1'b0, cmdEi = 1'b0, cmdDi = 1'b0, cmdReti = 1'b0;
  logic       epEnWr = 1'b0, genEnWr = 1'b0;
  logic [7:0] epEnWdata = '0;
  logic [2:0] genEnWdata = '0;
  logic [7:0] epEnRdata, status, pending;
  logic [2:0] genEnRdata;
  logic       callStrobe;
  logic [11:0] callVector;

  int checks = 0, fails = 0;

  logic [7:0]  mPend = '0;
  logic        mGie = 1'b0, mStb = 1'b0;
  logic [2:0]  mGen = '0;
  logic [4:0]  mEp = '0;
  logic [11:0] mVec = '0;

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .instrDone(instrDone),
    .cmdEi(cmdEi), .cmdDi(cmdDi), .cmdReti(cmdReti),
    .epEnWr(epEnWr), .epEnWdata(epEnWdata), .epEnRdata(epEnRdata),
    .genEnWr(genEnWr), .genEnWdata(genEnWdata), .genEnRdata(genEnRdata),
    .callStrobe(callStrobe), .callVector(callVector),
    .status(status), .pending(pending)
  );

  function automatic int lowestIdx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [7:0] expStatus(input logic [7:0] p, input logic [4:0] ep,
                                           input logic [2:0] gn, input logic g);
    logic [7:0] s = '0;
    s[7] = |(p & {ep, gn});
    s[2] = g;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    srcEvent = '0; instrDone = 0; cmdEi = 0; cmdDi = 0; cmdReti = 0;
    epEnWr = 0; genEnWr = 0;
  endtask

  task automatic step();
    logic [7:0] req;
    logic take;
    int idx;
    @(posedge clk);
    if (!rstN) begin
      mPend = '0; mGie = 0; mStb = 0; mGen = '0; mEp = '0; mVec = '0;
    end else begin
      req  = mPend & {mEp, mGen};
      take = instrDone & mGie & (|req);
      idx  = lowestIdx(req);
      mStb = take;
      if (take) mVec = 12'(4 + 2 * idx);
      mPend = (mPend & ~(take ? (8'd1 << idx) : 8'd0)) | srcEvent;
      if (take) mGie = 0;
      else if (cmdDi) mGie = 0;
      else if (cmdEi || cmdReti) mGie = 1;
      if (epEnWr) mEp = epEnWdata[4:0];
      if (genEnWr) mGen = genEnWdata;
    end
    @(negedge clk);
    check("R3 pending", 32'(pending), 32'(mPend));
    check("R2 epEnRdata", 32'(epEnRdata), {27'd0, mEp});
    check("R8 genEnRdata", 32'(genEnRdata), 32'(mGen));
    check("R10 status", 32'(status), 32'(expStatus(mPend, mEp, mGen, mGie)));
    check("R5 callStrobe", 32'(callStrobe), 32'(mStb));
    if (mStb) check("R6 callVector", 32'(callVector), 32'(mVec));
    clearIn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) step();
    @(negedge clk); rstN = 1;
    // R1 reset state
    check("R1 status", 32'(status), 0);
    check("R1 epEnRdata", 32'(epEnRdata), 0);
    check("R1 pending", 32'(pending), 0);
    check("R1 callStrobe", 32'(callStrobe), 0);

    // R2 reserved bits read zero
    epEnWr = 1; epEnWdata = 8'hFF; step();
    check("R2 reserved", 32'(epEnRdata), 32'h1F);
    epEnWr = 1; epEnWdata = 8'hE0; step();
    check("R2 reserved only", 32'(epEnRdata), 0);

    // R4 disabled pending source never calls
    srcEvent = 8'h08; cmdEi = 1; step();
    instrDone = 1; step();
    step();
    check("R4 no call", 32'(callStrobe), 0);
    check("R4 sense low", 32'(status[7]), 0);
    // R10 sense with global enable clear
    cmdDi = 1; step();
    epEnWr = 1; epEnWdata = 8'h01; step();
    check("R10 sense masked", 32'(status), 32'h80);

    // R6 priority, R7 selective clear
    srcEvent = 8'h22; genEnWr = 1; genEnWdata = 3'h7; step();
    epEnWr = 1; epEnWdata = 8'h1F; cmdEi = 1; step();
    instrDone = 1; step();
    check("R6 strobe", 32'(callStrobe), 1);
    check("R6 vector src1", 32'(callVector), 32'h006);
    check("R7 gie cleared", 32'(status[2]), 0);
    check("R7 only served cleared", 32'(pending), 32'h28);
    step();
    check("R5 one cycle", 32'(callStrobe), 0);

    // R9 return sets gie, next take is source 3
    cmdReti = 1; step();
    check("R9 gie set", 32'(status[2]), 1);
    instrDone = 1; step();
    check("R6 vector src3", 32'(callVector), 32'h00A);

    // R8 disable wins over enable
    cmdEi = 1; cmdDi = 1; step();
    check("R8 di wins", 32'(status[2]), 0);
    check("R8 pend untouched", 32'(pending), 32'h20);

    // R11 event during service keeps latch
    genEnWr = 1; genEnWdata = 3'h4; epEnWr = 1; epEnWdata = 8'h00; srcEvent = 8'h04; cmdEi = 1; step();
    instrDone = 1; srcEvent = 8'h04; step();
    check("R11 strobe", 32'(callStrobe), 1);
    check("R11 vector src2", 32'(callVector), 32'h008);
    check("R11 latch kept", 32'(pending[2]), 1);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 4 == 0) srcEvent = 8'($urandom);
      instrDone = ($urandom % 2) == 0;
      cmdEi     = ($urandom % 10) == 0;
      cmdDi     = ($urandom % 20) == 0;
      cmdReti   = ($urandom % 10) == 0;
      if ($urandom % 30 == 0) begin epEnWr = 1; epEnWdata = 8'($urandom); end
      if ($urandom % 30 == 0) begin genEnWr = 1; genEnWdata = 3'($urandom); end
      if ($urandom % 500 == 0) rstN = 0; else rstN = 1;
      step();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule